// File: doc/BRIEF.md
# Power-Management Event Status/Enable Registers

This block holds two groups of power-management event registers on a byte-wide I/O bus. A fixed-function group sits at a 16-byte aligned base. A general-purpose group sits at an 8-byte aligned base. Each group has a 16-bit status word at offsets 0–1, followed by a 16-bit enable word at offsets 2–3.

Hardware event pulses latch into the status bits, and the bits stay set until software writes a one to them. The single system control interrupt (SCI) output is a registered level. It is high whenever some status bit is set together with the enable bit at the same position.

Each group has its own mask parameters. These say which status bits exist and which of those have an enable bit. A status bit without an enable bit can be read but never interrupts. Bits that do not exist read zero and ignore writes. Each base address is supplied on an input. A base outside the permitted window switches the group's decode off.

Top module: `pm_event_regs`

## Requirements
- R1: After reset, every status and enable byte reads 00h and `sci` is 0.
- R2: A high `pm1_evt`/`gpe_evt` bit in a cycle sets the matching implemented status bit at that clock edge. A bus write never sets a status bit.
- R3: Writing a byte to a status byte clears each bit where the data is 1. Bits where the data is 0 keep their value.
- R4: When a hardware event and a write-one-to-clear hit the same status bit at the same edge, the bit ends up set.
- R5: Enable bytes are read/write at offsets 2 (low) and 3 (high). Enable bits outside the enable mask read 0 and ignore writes. In the fixed group by default, only bits 0 and 5 exist.
- R6: `sci` goes high on the clock edge after some status bit and its enable bit are both set. It goes low on the clock edge after the last such pair stops holding, whether by clearing the status bit or by disabling it.
- R7: A status bit with no enable bit never drives `sci`. This is fixed-group bit 4, the bus-master status.
- R8: Status bits outside the status mask read 0 and ignore events. In the fixed group by default, only bits 0 (timer), 4 (bus master) and 5 (global) exist.
- R9: The fixed-group base has its low 4 bits forced to zero and is valid from 100h to 3F0h. The general-purpose base has its low 3 bits forced to zero and is valid from 100h to 3F8h. A group with an invalid base reads 00h and ignores writes.
- R10: Address bit 0 selects the low byte (0) or the high byte (1) of a register. Offsets 4 and above inside a window read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pm1_base | input | 10 | Fixed-group I/O base address |
| gpe_base | input | 10 | General-purpose group I/O base address |
| io_addr | input | 10 | Bus address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Combinational read data for `io_addr` |
| pm1_evt | input | 16 | Fixed-group hardware event pulses |
| gpe_evt | input | 16 | General-purpose hardware event pulses |
| sci | output | 1 | Registered interrupt level |

## Verification
The hardest case to reach from the ports is the same-edge collision of an event pulse and a write-one-to-clear on one status bit. The bench drives the event input and the bus write together in one low clock phase, so both land on the same edge, and then reads the bit back. The SCI latency is checked at both edges. The bench samples in the half cycle right after the setting or clearing edge, where `sci` must still hold its old value, and then again one clock later.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  parameter int unsigned IO_AW = 10;
  parameter int unsigned REG_W = 16;

  // Base with its alignment bits forced to zero.
  function automatic logic [IO_AW-1:0] align_base(input logic [IO_AW-1:0] base,
                                                  input int unsigned align_log2);
    logic [IO_AW-1:0] m;
    m = '1;
    m = m << align_log2;
    return base & m;
  endfunction

  // Aligned base inside the permitted window.
  function automatic logic base_valid(input logic [IO_AW-1:0] base,
                                      input int unsigned align_log2,
                                      input logic [IO_AW-1:0] lo,
                                      input logic [IO_AW-1:0] hi);
    logic [IO_AW-1:0] b;
    b = align_base(base, align_log2);
    return (b >= lo) && (b <= hi);
  endfunction

  // Place a byte into the low or high half of a register word.
  function automatic logic [REG_W-1:0] byte_lane(input logic [7:0] d, input logic hi);
    return hi ? {d, 8'h00} : {8'h00, d};
  endfunction
endpackage

// File: rtl/pm_evt_decode.sv
module pm_evt_decode
  import pm_evt_pkg::*;
#(
  parameter int unsigned ALIGN_LOG2 = 4,
  parameter logic [IO_AW-1:0] BASE_LO = 10'h100,
  parameter logic [IO_AW-1:0] BASE_HI = 10'h3F0
) (
  input  logic [IO_AW-1:0] base_i,
  input  logic [IO_AW-1:0] addr_i,
  output logic             hit_o,
  output logic             en_sel_o,
  output logic             hi_sel_o
);
  localparam int unsigned OFF_W = ALIGN_LOG2;

  logic [IO_AW-1:0] eff_base;
  logic             win_hit;
  logic [OFF_W-1:0] off;

  always_comb begin
    eff_base = align_base(base_i, ALIGN_LOG2);
    off      = addr_i[OFF_W-1:0];
    win_hit  = (addr_i[IO_AW-1:OFF_W] == eff_base[IO_AW-1:OFF_W]);
    hit_o    = base_valid(base_i, ALIGN_LOG2, BASE_LO, BASE_HI) && win_hit
               && (off[OFF_W-1:2] == '0);
    en_sel_o = off[1];
    hi_sel_o = off[0];
  end
endmodule

// File: rtl/pm_evt_group.sv
module pm_evt_group
  import pm_evt_pkg::*;
#(
  parameter int unsigned ALIGN_LOG2 = 4,
  parameter logic [IO_AW-1:0] BASE_LO = 10'h100,
  parameter logic [IO_AW-1:0] BASE_HI = 10'h3F0,
  parameter logic [REG_W-1:0] STS_MASK = 16'h0031,
  parameter logic [REG_W-1:0] EN_MASK  = 16'h0021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] base_i,
  input  logic [IO_AW-1:0] addr_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  input  logic [REG_W-1:0] evt_i,
  output logic [7:0]       rdata_o,
  output logic             hit_o,
  output logic             pend_o,
  output logic [REG_W-1:0] sts_o,
  output logic [REG_W-1:0] en_o,
  output logic [REG_W-1:0] clr_o
);
  logic             en_sel, hi_sel;
  logic [REG_W-1:0] sts_q, en_q, set_v, lane_d, lane_m, en_wr_m;
  logic             sts_wr, en_wr;

  pm_evt_decode #(
    .ALIGN_LOG2(ALIGN_LOG2), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
  ) u_dec (
    .base_i(base_i), .addr_i(addr_i),
    .hit_o(hit_o), .en_sel_o(en_sel), .hi_sel_o(hi_sel)
  );

  always_comb begin
    sts_wr  = hit_o && wr_i && !en_sel;
    en_wr   = hit_o && wr_i && en_sel;
    lane_d  = byte_lane(wdata_i, hi_sel);
    lane_m  = byte_lane(8'hFF, hi_sel);
    clr_o   = sts_wr ? (lane_d & STS_MASK) : '0;
    set_v   = evt_i & STS_MASK;
    en_wr_m = en_wr ? (lane_m & EN_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_o) | set_v;          // set wins over clear
      en_q  <= (en_q & ~en_wr_m) | (lane_d & en_wr_m);
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (hit_o) begin
      case ({en_sel, hi_sel})
        2'b00:   rdata_o = sts_q[7:0];
        2'b01:   rdata_o = sts_q[15:8];
        2'b10:   rdata_o = en_q[7:0];
        default: rdata_o = en_q[15:8];
      endcase
    end
    pend_o = |(sts_q & en_q);
    sts_o  = sts_q;
    en_o   = en_q;
  end
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
  import pm_evt_pkg::*;
#(
  parameter logic [REG_W-1:0] PM1_STS_MASK = 16'h0031,
  parameter logic [REG_W-1:0] PM1_EN_MASK  = 16'h0021,
  parameter logic [REG_W-1:0] GPE_STS_MASK = 16'hFFFF,
  parameter logic [REG_W-1:0] GPE_EN_MASK  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] pm1_base,
  input  logic [IO_AW-1:0] gpe_base,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  input  logic [REG_W-1:0] pm1_evt,
  input  logic [REG_W-1:0] gpe_evt,
  output logic             sci
);
  logic [7:0]       pm1_rd, gpe_rd;
  logic             pm1_hit, gpe_hit, pm1_pend, gpe_pend, sci_q;
  logic [REG_W-1:0] pm1_sts, pm1_en, pm1_clr, gpe_sts, gpe_en, gpe_clr;

  pm_evt_group #(
    .ALIGN_LOG2(4), .BASE_LO(10'h100), .BASE_HI(10'h3F0),
    .STS_MASK(PM1_STS_MASK), .EN_MASK(PM1_EN_MASK)
  ) u_pm1 (
    .clk(clk), .rst_n(rst_n), .base_i(pm1_base), .addr_i(io_addr),
    .wr_i(io_wr), .wdata_i(io_wdata), .evt_i(pm1_evt),
    .rdata_o(pm1_rd), .hit_o(pm1_hit), .pend_o(pm1_pend),
    .sts_o(pm1_sts), .en_o(pm1_en), .clr_o(pm1_clr)
  );

  pm_evt_group #(
    .ALIGN_LOG2(3), .BASE_LO(10'h100), .BASE_HI(10'h3F8),
    .STS_MASK(GPE_STS_MASK), .EN_MASK(GPE_EN_MASK)
  ) u_gpe (
    .clk(clk), .rst_n(rst_n), .base_i(gpe_base), .addr_i(io_addr),
    .wr_i(io_wr), .wdata_i(io_wdata), .evt_i(gpe_evt),
    .rdata_o(gpe_rd), .hit_o(gpe_hit), .pend_o(gpe_pend),
    .sts_o(gpe_sts), .en_o(gpe_en), .clr_o(gpe_clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sci_q <= 1'b0;
    else        sci_q <= pm1_pend | gpe_pend;
  end

  assign io_rdata = pm1_hit ? pm1_rd : gpe_rd;
  assign sci      = sci_q;
endmodule

// File: rtl/pm_event_regs_chk.sv
module pm_event_regs_chk
  import pm_evt_pkg::*;
#(
  parameter logic [REG_W-1:0] STS_MASK = 16'h0031
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pm1_pend,
  input logic             gpe_pend,
  input logic             sci,
  input logic [REG_W-1:0] pm1_sts,
  input logic [REG_W-1:0] pm1_evt,
  input logic [REG_W-1:0] pm1_clr,
  input logic             pm1_hit,
  input logic             gpe_hit,
  input logic [7:0]       io_rdata
);
  // R6: a pending pair raises sci on the next edge
  a_r6_sci_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (pm1_pend || gpe_pend) |=> sci);
  // R6: no pending pair drops sci on the next edge
  a_r6_sci_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm1_pend || gpe_pend) |=> !sci);
  // R2: a status bit rises only where an event was present
  a_r2_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pm1_sts & ~$past(pm1_sts) & ~$past(pm1_evt)) == '0);
  // R4: an implemented event always leaves its bit set
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pm1_evt) & STS_MASK & ~pm1_sts) == '0);
  // R3: a clear without a coincident event empties the bit
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (pm1_sts & $past(pm1_clr & ~pm1_evt)) == '0);
  // R9: no decoded group means the bus reads zero
  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm1_hit && !gpe_hit) |-> (io_rdata == 8'h00));
endmodule

bind pm_event_regs pm_event_regs_chk #(.STS_MASK(PM1_STS_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .pm1_pend(pm1_pend), .gpe_pend(gpe_pend),
  .sci(sci), .pm1_sts(pm1_sts), .pm1_evt(pm1_evt), .pm1_clr(pm1_clr),
  .pm1_hit(pm1_hit), .gpe_hit(gpe_hit), .io_rdata(io_rdata)
);

// File: tb/sim_pm_event_regs.sv
module sim_pm_event_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] PM1_B = 10'h200;
  localparam logic [9:0] GPE_B = 10'h308;

  logic       clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0;
  logic [9:0] pm1_base = PM1_B, gpe_base = GPE_B, io_addr = '0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [15:0] pm1_evt = '0, gpe_evt = '0;
  logic       sci;
  int checks = 0, errors = 0;
  bit done = 0;

  pm_event_regs u0 (
    .clk(clk), .rst_n(rst_n), .pm1_base(pm1_base), .gpe_base(gpe_base),
    .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pm1_evt(pm1_evt), .gpe_evt(gpe_evt), .sci(sci)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; #1 d = io_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d); check(req, d, exp);
  endtask

  task automatic pulse(input logic [15:0] p, input logic [15:0] g);
    @(negedge clk); pm1_evt = p; gpe_evt = g;
    @(negedge clk); pm1_evt = '0; gpe_evt = '0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) begin
      wr(PM1_B + 10'(i), i < 2 ? 8'hFF : 8'h00);
      wr(GPE_B + 10'(i), i < 2 ? 8'hFF : 8'h00);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      rd_chk("R1 pm1", PM1_B + 10'(i), 8'h00);
      rd_chk("R1 gpe", GPE_B + 10'(i), 8'h00);
    end
    check("R1 sci", {7'd0, sci}, 8'h00);
  endtask

  task automatic t_status();
    clear_all();
    pulse(16'h0001, '0);
    rd_chk("R2 timer set", PM1_B, 8'h01);
    pulse(16'hFFFF, '0);
    rd_chk("R8 low byte mask", PM1_B, 8'h31);
    rd_chk("R8 high byte reserved", PM1_B + 10'd1, 8'h00);
    wr(PM1_B, 8'h00);
    rd_chk("R3 write zero keeps", PM1_B, 8'h31);
    wr(PM1_B, 8'h01);
    rd_chk("R3 w1c one bit", PM1_B, 8'h30);
    wr(PM1_B, 8'hFF);
    wr(PM1_B, 8'hFF);
    rd_chk("R2 write cannot set", PM1_B, 8'h00);
  endtask

  task automatic t_enable();
    clear_all();
    wr(PM1_B + 10'd2, 8'hFF);
    rd_chk("R5 pm1 en low mask", PM1_B + 10'd2, 8'h21);
    wr(PM1_B + 10'd3, 8'hFF);
    rd_chk("R5 pm1 en high none", PM1_B + 10'd3, 8'h00);
    wr(GPE_B + 10'd3, 8'hA5);
    rd_chk("R10 gpe en high byte", GPE_B + 10'd3, 8'hA5);
    rd_chk("R10 gpe en low untouched", GPE_B + 10'd2, 8'h00);
    rd_chk("R10 past offset 3", PM1_B + 10'd4, 8'h00);
  endtask

  task automatic t_sci();
    clear_all();
    wr(PM1_B + 10'd2, 8'h21);
    pulse(16'h0010, '0);
    repeat (2) @(negedge clk);
    check("R7 bus-master no sci", {7'd0, sci}, 8'h00);
    rd_chk("R7 bus-master status visible", PM1_B, 8'h10);
    // set edge then one more edge
    @(negedge clk); pm1_evt = 16'h0001;
    @(posedge clk); @(negedge clk); pm1_evt = '0;
    check("R6 sci not yet", {7'd0, sci}, 8'h00);
    @(negedge clk);
    check("R6 sci raised", {7'd0, sci}, 8'h01);
    // clear edge: sci still high right after, low one edge later
    @(negedge clk); io_addr = PM1_B; io_wdata = 8'h01; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
    check("R6 sci holds after clear", {7'd0, sci}, 8'h01);
    @(negedge clk);
    check("R6 sci drops after clear", {7'd0, sci}, 8'h00);
    // disable path
    pulse(16'h0020, '0);
    @(negedge clk);
    check("R6 sci from global", {7'd0, sci}, 8'h01);
    wr(PM1_B + 10'd2, 8'h00);
    @(negedge clk);
    check("R6 sci drops on disable", {7'd0, sci}, 8'h00);
    // gpe path, high byte
    wr(GPE_B + 10'd3, 8'h02);
    pulse('0, 16'h0200);
    rd_chk("R10 gpe status high byte", GPE_B + 10'd1, 8'h02);
    check("R6 sci from gpe", {7'd0, sci}, 8'h01);
  endtask

  task automatic t_race();
    clear_all();
    pulse(16'h0001, '0);
    @(negedge clk); io_addr = PM1_B; io_wdata = 8'h01; io_wr = 1'b1; pm1_evt = 16'h0001;
    @(negedge clk); io_wr = 1'b0; pm1_evt = '0;
    rd_chk("R4 set wins", PM1_B, 8'h01);
  endtask

  task automatic t_decode();
    clear_all();
    pm1_base = 10'h205;
    wr(10'h202, 8'h01);
    rd_chk("R9 low bits forced zero", 10'h202, 8'h01);
    pm1_base = 10'h0F0;
    rd_chk("R9 pm1 below range reads 0", 10'h0F2, 8'h00);
    wr(10'h0F2, 8'h20);
    pm1_base = PM1_B;
    rd_chk("R9 pm1 write ignored", PM1_B + 10'd2, 8'h01);
    pm1_base = 10'h3F0;
    rd_chk("R9 pm1 top of range", 10'h3F2, 8'h01);
    pm1_base = PM1_B;
    gpe_base = 10'h3F8;
    wr(10'h3FA, 8'h44);
    rd_chk("R9 gpe top of range", 10'h3FA, 8'h44);
    gpe_base = 10'h0F8;
    rd_chk("R9 gpe below range reads 0", 10'h0FA, 8'h00);
    gpe_base = 10'h3F8;
    rd_chk("R9 gpe state kept", 10'h3FA, 8'h44);
    gpe_base = GPE_B;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status();
    t_enable();
    t_sci();
    t_race();
    t_decode();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule